// File: doc/BRIEF.md
# Strap-Probing Boot Source Selector

This block runs once after reset and decides where the chip boots from. It looks at a group of five straps, pins 59 to 63 of the pad ring, presented as `pinIn[0]` (pin 59) up to `pinIn[4]` (pin 63). To learn how each pin is wired on the board, it drives a shared weak internal pull setting onto the whole group in three phases: no pull, weak pull-down, weak pull-up. In each phase it waits a programmable number of cycles before it samples the pins. The three samples give each pin one of four strap classes.

From the classes it either settles on a source at once or asks an external handshake engine to try a source. The engine answers with an acknowledge or a failure. Any attempt that gets no answer within a fixed cycle budget counts as a failure. The flash strap leads to two tries, one for each flash wiring, and after both it falls back to serial. When no strap matches, serial boot is chosen with a flag that asks the serial loader for its longer wait. The result is held until the next reset.

Top module: `bootStrapSelect`

## Requirements
- R1: While reset is asserted and in the cycle it is released, `pullMode` is 0 (no pull), `reqValid` and `done` are low and `strapClass` is all zero.
- R2: After reset the pull setting goes through 0 (none), 1 (weak pull-down) and 2 (weak pull-up) in that order, and holds each for exactly `settleLen`+1 cycles. It then returns to 0 and stays there.
- R3: Each pin's 2-bit field `strapClass[2k+1:2k]` is 3 (strong pull-up) if it read high under the internal pull-down; 1 (pull-down) if it read low under the internal pull-up; 2 (weak pull-up) if it read high with no pull; otherwise 0 (floating). A pin counts as pulled up when its class is 2 or 3.
- R4: If pin 63 (`pinIn[4]`) is pulled up, serial boot (`bootSrc` 0) is chosen with no attempt and with `longWait` low.
- R5: Otherwise, if pins 61 and 60 are both pulled up, I2C EEPROM boot (`bootSrc` 1) is chosen with no attempt.
- R6: Otherwise, if pin 61 is pulled up, shared-data flash (`reqSrc` 2) is tried first, then split-data flash (`reqSrc` 3). The first one acknowledged becomes `bootSrc`. If both fail, the result is serial with `longWait` low.
- R7: Otherwise, if pin 59 is pulled up, SD boot in SPI mode (`reqSrc` 4) is tried. On success `bootSrc` is 4; on failure it is serial with `longWait` low.
- R8: If no strap matches, serial boot is chosen with `longWait` high. `longWait` is never high with any other source.
- R9: An attempt that gets neither acknowledge nor fail is treated as a failure after exactly `TIMEOUT_CYC`+1 cycles of `reqValid` for that source.
- R10: When acknowledge and fail arrive in the same cycle of an attempt, the acknowledge wins.
- R11: Acknowledge or fail pulses while `reqValid` is low have no effect on the outcome.
- R12: Once `done` rises it stays high and `bootSrc`/`longWait` stay stable until reset; `reqValid` is low and the pull setting is 0 while `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; a probe starts when it is released |
| pinIn | input | PIN_W | Pad levels of pins 59 (bit 0) to 63 (bit 4) |
| settleLen | input | SET_W | Settle cycles after each pull change, minus one |
| ackIn | input | 1 | Engine reports success of the current attempt |
| failIn | input | 1 | Engine reports failure of the current attempt |
| pullMode | output | 2 | Internal pull for the pin group: 0 none, 1 down, 2 up |
| reqValid | output | 1 | An attempt is in progress |
| reqSrc | output | 3 | Source under attempt: 2 shared flash, 3 split flash, 4 SD |
| done | output | 1 | Decision is final |
| bootSrc | output | 3 | Chosen source: 0 serial, 1 I2C, 2/3 flash, 4 SD |
| longWait | output | 1 | Serial chosen because no strap matched |
| strapClass | output | 2*PIN_W | Strap class per pin, 2 bits each |

## Verification
The hardest situation to reach is the full flash fallback chain: the flash strap must be present, the serial strap absent and pin 60 not pulled up, and both flash tries must end without an acknowledge, one of them by silence so the timeout path runs. The bench models each pad from a chosen strap class and the current pull, and models the engine with a chosen answer (ack, fail, both, silent) and a random latency for each source. Directed cases force every fallback path, and random cases mix strap classes and answers. Stray acknowledge and fail pulses are injected outside attempts to show they are ignored.

// File: rtl/bootStrapPkg.sv
package bootStrapPkg;

  typedef enum logic [2:0] {
    SRC_SERIAL       = 3'd0,
    SRC_I2C          = 3'd1,
    SRC_FLASH_SHARED = 3'd2,
    SRC_FLASH_SPLIT  = 3'd3,
    SRC_SD           = 3'd4
  } bootSrc_e;

  typedef enum logic [1:0] {
    PULL_OFF  = 2'd0,
    PULL_DOWN = 2'd1,
    PULL_UP   = 2'd2
  } pull_e;

  localparam logic [1:0] CLS_FLOAT  = 2'd0;
  localparam logic [1:0] CLS_DOWN   = 2'd1;
  localparam logic [1:0] CLS_WEAKUP = 2'd2;
  localparam logic [1:0] CLS_STRONG = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic capOff;
    logic capDown;
    logic capUp;
    logic cntClr;
  } pathCtl_t;

endpackage

// File: rtl/bootStrapPath.sv
module bootStrapPath
  import bootStrapPkg::*;
#(
  parameter int PIN_W       = 5,
  parameter int SET_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_W-1:0]   pinIn,
  input  logic [SET_W-1:0]   settleLen,
  input  pathCtl_t           ctl,
  output logic               settleHit,
  output logic               timeoutHit,
  output logic [PIN_W-1:0]   pinUp,
  output logic [2*PIN_W-1:0] strapClass
);

  localparam int TO_W  = $clog2(TIMEOUT_CYC + 1);
  localparam int CNT_W = (TO_W > SET_W) ? TO_W : SET_W;

  logic [CNT_W-1:0] cnt;
  logic [PIN_W-1:0] sOff, sDown, sUp;

  // shared cycle counter: settle windows and attempt budgets
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      cnt <= '0;
    else if (ctl.cntClr)            cnt <= '0;
    else if (cnt != {CNT_W{1'b1}})  cnt <= cnt + CNT_W'(1);
  end

  assign settleHit  = (cnt == CNT_W'(settleLen));
  assign timeoutHit = (cnt == CNT_W'(TIMEOUT_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sOff  <= '0;
      sDown <= '0;
      sUp   <= '0;
    end else begin
      if (ctl.capOff)  sOff  <= pinIn;
      if (ctl.capDown) sDown <= pinIn;
      if (ctl.capUp)   sUp   <= pinIn;
    end
  end

  logic classValid;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          classValid <= 1'b0;
    else if (ctl.capUp) classValid <= 1'b1;
  end

  for (genvar k = 0; k < PIN_W; k++) begin : gPin
    logic [1:0] cls;
    always_comb begin
      if (!classValid)    cls = CLS_FLOAT;
      else if (sDown[k])  cls = CLS_STRONG;
      else if (!sUp[k])   cls = CLS_DOWN;
      else if (sOff[k])   cls = CLS_WEAKUP;
      else                cls = CLS_FLOAT;
    end
    assign strapClass[2*k +: 2] = cls;
    assign pinUp[k]             = cls[1];
  end

endmodule

// File: rtl/bootStrapCtl.sv
module bootStrapCtl
  import bootStrapPkg::*;
#(
  parameter int PIN_W   = 5,
  parameter int RX_IDX  = 4,
  parameter int SEL_IDX = 2,
  parameter int CLK_IDX = 1,
  parameter int AUX_IDX = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             settleHit,
  input  logic             timeoutHit,
  input  logic [PIN_W-1:0] pinUp,
  input  logic             ackIn,
  input  logic             failIn,
  output pathCtl_t         ctl,
  output logic [1:0]       pullMode,
  output logic             reqValid,
  output logic [2:0]       reqSrc,
  output logic             done,
  output logic [2:0]       bootSrc,
  output logic             longWait
);

  typedef enum logic [2:0] {
    ST_OFF, ST_DOWN, ST_UP, ST_DECIDE, ST_TRY, ST_DONE
  } state_e;

  state_e   state, stateNxt;
  bootSrc_e curSrc, curSrcNxt, resSrc, resSrcNxt;
  logic     longNxt, longReg;

  always_comb begin
    stateNxt  = state;
    curSrcNxt = curSrc;
    resSrcNxt = resSrc;
    longNxt   = longReg;
    ctl       = '0;
    unique case (state)
      ST_OFF: if (settleHit) begin
        ctl.capOff = 1'b1; ctl.cntClr = 1'b1; stateNxt = ST_DOWN;
      end
      ST_DOWN: if (settleHit) begin
        ctl.capDown = 1'b1; ctl.cntClr = 1'b1; stateNxt = ST_UP;
      end
      ST_UP: if (settleHit) begin
        ctl.capUp = 1'b1; ctl.cntClr = 1'b1; stateNxt = ST_DECIDE;
      end
      ST_DECIDE: begin
        ctl.cntClr = 1'b1;
        if (pinUp[RX_IDX]) begin
          resSrcNxt = SRC_SERIAL; stateNxt = ST_DONE;
        end else if (pinUp[SEL_IDX] && pinUp[CLK_IDX]) begin
          resSrcNxt = SRC_I2C; stateNxt = ST_DONE;
        end else if (pinUp[SEL_IDX]) begin
          curSrcNxt = SRC_FLASH_SHARED; stateNxt = ST_TRY;
        end else if (pinUp[AUX_IDX]) begin
          curSrcNxt = SRC_SD; stateNxt = ST_TRY;
        end else begin
          resSrcNxt = SRC_SERIAL; longNxt = 1'b1; stateNxt = ST_DONE;
        end
      end
      ST_TRY: begin
        if (ackIn) begin
          resSrcNxt = curSrc; stateNxt = ST_DONE;
        end else if (failIn || timeoutHit) begin
          ctl.cntClr = 1'b1;
          if (curSrc == SRC_FLASH_SHARED) begin
            curSrcNxt = SRC_FLASH_SPLIT;
          end else begin
            resSrcNxt = SRC_SERIAL; stateNxt = ST_DONE;
          end
        end
      end
      default: stateNxt = ST_DONE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_OFF;
      curSrc  <= SRC_SERIAL;
      resSrc  <= SRC_SERIAL;
      longReg <= 1'b0;
    end else begin
      state   <= stateNxt;
      curSrc  <= curSrcNxt;
      resSrc  <= resSrcNxt;
      longReg <= longNxt;
    end
  end

  always_comb begin
    unique case (state)
      ST_DOWN: pullMode = PULL_DOWN;
      ST_UP:   pullMode = PULL_UP;
      default: pullMode = PULL_OFF;
    endcase
  end

  assign reqValid = (state == ST_TRY);
  assign reqSrc   = curSrc;
  assign done     = (state == ST_DONE);
  assign bootSrc  = resSrc;
  assign longWait = longReg;

endmodule

// File: rtl/bootStrapSelect.sv
module bootStrapSelect
  import bootStrapPkg::*;
#(
  parameter int PIN_W       = 5,
  parameter int SET_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PIN_W-1:0]   pinIn,
  input  logic [SET_W-1:0]   settleLen,
  input  logic               ackIn,
  input  logic               failIn,
  output logic [1:0]         pullMode,
  output logic               reqValid,
  output logic [2:0]         reqSrc,
  output logic               done,
  output logic [2:0]         bootSrc,
  output logic               longWait,
  output logic [2*PIN_W-1:0] strapClass
);

  pathCtl_t         ctl;
  logic             settleHit, timeoutHit;
  logic [PIN_W-1:0] pinUp;

  bootStrapPath #(.PIN_W(PIN_W), .SET_W(SET_W), .TIMEOUT_CYC(TIMEOUT_CYC)) uPath (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .settleLen(settleLen), .ctl(ctl),
    .settleHit(settleHit), .timeoutHit(timeoutHit), .pinUp(pinUp),
    .strapClass(strapClass)
  );

  bootStrapCtl #(.PIN_W(PIN_W)) uCtl (
    .clk(clk), .rstN(rstN), .settleHit(settleHit), .timeoutHit(timeoutHit),
    .pinUp(pinUp), .ackIn(ackIn), .failIn(failIn), .ctl(ctl),
    .pullMode(pullMode), .reqValid(reqValid), .reqSrc(reqSrc), .done(done),
    .bootSrc(bootSrc), .longWait(longWait)
  );

endmodule

// File: rtl/bootStrapChk.sv
module bootStrapChk #(
  parameter int SET_W       = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input logic             clk,
  input logic             rstN,
  input logic [SET_W-1:0] settleLen,
  input logic             ackIn,
  input logic [1:0]       pullMode,
  input logic             reqValid,
  input logic [2:0]       reqSrc,
  input logic             done,
  input logic [2:0]       bootSrc,
  input logic             longWait
);

  logic [1:0] lastMode;
  int         runLen;
  logic       lastValid;
  logic [2:0] lastSrc;
  int         attLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lastMode  <= 2'd0;
      runLen    <= 1;
      lastValid <= 1'b0;
      lastSrc   <= 3'd0;
      attLen    <= 0;
    end else begin
      lastMode  <= pullMode;
      runLen    <= (pullMode == lastMode) ? runLen + 1 : 1;
      lastValid <= reqValid;
      lastSrc   <= reqSrc;
      if (!reqValid)                             attLen <= 0;
      else if (!lastValid || reqSrc != lastSrc)  attLen <= 1;
      else                                       attLen <= attLen + 1;
    end
  end

  // R2
  settle_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pullMode != lastMode && lastMode != 2'd0) |-> (runLen == int'(settleLen) + 1));

  // R9
  attempt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (attLen <= TIMEOUT_CYC + 1));

  // R10
  ack_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ackIn) |=> (done && bootSrc == $past(reqSrc)));

  // R12
  done_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (done && $stable(bootSrc) && $stable(longWait)));

  // R12
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!reqValid && pullMode == 2'd0));

  // R8
  long_serial_chk: assert property (@(posedge clk) disable iff (!rstN)
    longWait |-> (bootSrc == 3'd0));

  // R12
  try_pulloff_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (pullMode == 2'd0 && !done));

endmodule

bind bootStrapSelect bootStrapChk #(.SET_W(SET_W), .TIMEOUT_CYC(TIMEOUT_CYC)) uChk (
  .clk(clk), .rstN(rstN), .settleLen(settleLen), .ackIn(ackIn),
  .pullMode(pullMode), .reqValid(reqValid), .reqSrc(reqSrc), .done(done),
  .bootSrc(bootSrc), .longWait(longWait)
);

// File: tb/sim_bootStrapSelect.sv
module sim_bootStrapSelect;

  localparam int TO = 40;
  localparam int R_ACK = 0, R_FAIL = 1, R_SILENT = 2, R_BOTH = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] pinIn;
  logic [7:0] settleLen = 8'd3;
  logic       ackIn = 1'b0, failIn = 1'b0;
  logic [1:0] pullMode;
  logic       reqValid, done, longWait;
  logic [2:0] reqSrc, bootSrc;
  logic [9:0] strapClass;

  int nChk = 0, nBad = 0;
  logic [1:0] cls [5];
  int  resp [5];
  int  respLat;
  bit  strayOn = 1'b0;

  always #5 clk = ~clk;

  bootStrapSelect #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .settleLen(settleLen),
    .ackIn(ackIn), .failIn(failIn), .pullMode(pullMode), .reqValid(reqValid),
    .reqSrc(reqSrc), .done(done), .bootSrc(bootSrc), .longWait(longWait),
    .strapClass(strapClass)
  );

  // pad model: strong up beats internal down, internal down beats weak up
  always_comb begin
    for (int k = 0; k < 5; k++) begin
      case (cls[k])
        2'd3:    pinIn[k] = 1'b1;
        2'd2:    pinIn[k] = (pullMode != 2'd1);
        2'd1:    pinIn[k] = 1'b0;
        default: pinIn[k] = (pullMode == 2'd2);
      endcase
    end
  end

  // handshake engine model
  bit         busy = 1'b0;
  logic [2:0] busySrc = 3'd0;
  int         wcnt = 0;
  always @(negedge clk) begin
    ackIn  = 1'b0;
    failIn = 1'b0;
    if (!rstN) busy = 1'b0;
    else if (reqValid) begin
      if (!busy || reqSrc != busySrc) begin
        busy = 1'b1; busySrc = reqSrc; wcnt = 0;
      end else wcnt++;
      if (wcnt == respLat) begin
        case (resp[reqSrc])
          R_ACK:  ackIn = 1'b1;
          R_FAIL: failIn = 1'b1;
          R_BOTH: begin ackIn = 1'b1; failIn = 1'b1; end
          default: ;
        endcase
      end
    end else begin
      busy = 1'b0;
      if (strayOn) begin
        ackIn  = 1'($urandom_range(1, 0));
        failIn = 1'($urandom_range(1, 0));
      end
    end
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nBad++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // expected outcome from the requirements
  int expSrc, expLong, expN;
  int expAtt [2];
  function automatic bit isUp(input logic [1:0] c);
    return c[1];
  endfunction
  function automatic bit ok(input int r);
    return (r == R_ACK) || (r == R_BOTH);
  endfunction
  task automatic predict();
    expLong = 0; expN = 0;
    if (isUp(cls[4])) expSrc = 0;                        // R4
    else if (isUp(cls[2]) && isUp(cls[1])) expSrc = 1;   // R5
    else if (isUp(cls[2])) begin                         // R6
      expAtt[0] = 2; expN = 1;
      if (ok(resp[2])) expSrc = 2;
      else begin
        expAtt[1] = 3; expN = 2;
        expSrc = ok(resp[3]) ? 3 : 0;
      end
    end else if (isUp(cls[0])) begin                     // R7
      expAtt[0] = 4; expN = 1;
      expSrc = ok(resp[4]) ? 4 : 0;
    end else begin                                       // R8
      expSrc = 0; expLong = 1;
    end
  endtask

  task automatic runCase(input string tag);
    int phase, d0, d1, d2, nAtt, it;
    int att [4];
    int attDur [4];
    bit lastV;
    logic [2:0] lastS;
    logic [9:0] expCls;
    logic [2:0] holdSrc;
    logic holdLong;
    predict();
    for (int k = 0; k < 5; k++) expCls[2*k +: 2] = cls[k];
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk({tag, " R1 reset outputs"}, {pullMode, reqValid, done, strapClass}, 0);
    rstN = 1'b1;
    chk({tag, " R1 release outputs"}, {pullMode, reqValid, done, strapClass}, 0);
    phase = 0; d0 = 0; d1 = 0; d2 = 0; nAtt = 0; lastV = 1'b0; lastS = 3'd0;
    for (it = 0; it < 3000; it++) begin
      case (phase)
        0: if (pullMode == 2'd0) d0++; else if (pullMode == 2'd1) begin phase = 1; d1 = 1; end else phase = 9;
        1: if (pullMode == 2'd1) d1++; else if (pullMode == 2'd2) begin phase = 2; d2 = 1; end else phase = 9;
        2: if (pullMode == 2'd2) d2++; else if (pullMode == 2'd0) phase = 3; else phase = 9;
        3: if (pullMode != 2'd0) phase = 9;
        default: ;
      endcase
      if (reqValid) begin
        if ((!lastV || reqSrc != lastS) && nAtt < 4) begin
          att[nAtt] = int'(reqSrc); attDur[nAtt] = 1; nAtt++;
        end else if (nAtt > 0) attDur[nAtt-1]++;
      end
      lastV = reqValid; lastS = reqSrc;
      if (done) break;
      @(negedge clk);
    end
    chk({tag, " R12 done reached"}, int'(done), 1);
    chk({tag, " R2 pull order"}, phase, 3);
    chk({tag, " R2 off duration"}, d0, int'(settleLen) + 1);
    chk({tag, " R2 down duration"}, d1, int'(settleLen) + 1);
    chk({tag, " R2 up duration"}, d2, int'(settleLen) + 1);
    chk({tag, " R3 strap classes"}, int'(strapClass), int'(expCls));
    chk({tag, " R4-R7 attempt count"}, nAtt, expN);
    for (int a = 0; a < expN && a < nAtt; a++) begin
      chk({tag, " R6 R7 attempt source"}, att[a], expAtt[a]);
      if (resp[expAtt[a]] == R_SILENT)
        chk({tag, " R9 timeout length"}, attDur[a], TO + 1);
    end
    chk({tag, " R4-R8 bootSrc"}, int'(bootSrc), expSrc);
    chk({tag, " R8 longWait"}, int'(longWait), expLong);
    // R11 R12: stray pulses after done change nothing
    holdSrc = bootSrc; holdLong = longWait;
    repeat (6) @(negedge clk);
    chk({tag, " R12 hold"}, {done, bootSrc, longWait, reqValid, pullMode},
        {1'b1, holdSrc, holdLong, 1'b0, 2'd0});
  endtask

  task automatic setCls(input int c4, c3, c2, c1, c0);
    cls[4] = 2'(c4); cls[3] = 2'(c3); cls[2] = 2'(c2); cls[1] = 2'(c1); cls[0] = 2'(c0);
  endtask
  task automatic setResp(input int r2, r3, r4);
    resp[0] = R_SILENT; resp[1] = R_SILENT; resp[2] = r2; resp[3] = r3; resp[4] = r4;
  endtask

  initial begin
    void'($urandom(32'd4242));
    respLat = 1;
    setResp(R_ACK, R_ACK, R_ACK);
    // R8 all floating
    setCls(0, 0, 0, 0, 0); settleLen = 8'd3; runCase("nostrap");
    // R4 strong and weak serial straps, R3 pull-down class
    setCls(3, 1, 3, 3, 3); runCase("rx_strong");
    setCls(2, 0, 0, 0, 0); settleLen = 8'd0; runCase("rx_weak_settle0");
    // R5 I2C, mixed strong/weak
    setCls(1, 2, 3, 2, 0); settleLen = 8'd5; runCase("i2c");
    // R6 shared flash ack
    setCls(0, 0, 3, 1, 0); setResp(R_ACK, R_FAIL, R_FAIL); runCase("flash_shared");
    // R6 shared fails, split acks
    setResp(R_FAIL, R_ACK, R_FAIL); runCase("flash_split");
    // R6 R9 both silent -> serial
    setResp(R_SILENT, R_SILENT, R_ACK); runCase("flash_timeout");
    // R6 fail then silent
    setResp(R_FAIL, R_SILENT, R_ACK); respLat = 0; runCase("flash_fail_to");
    // R7 SD ack and SD timeout
    setCls(1, 0, 0, 0, 2); setResp(R_ACK, R_ACK, R_ACK); respLat = 2; runCase("sd_ack");
    setResp(R_ACK, R_ACK, R_SILENT); runCase("sd_timeout");
    // R10 ack and fail together
    setCls(0, 0, 2, 0, 0); setResp(R_BOTH, R_FAIL, R_FAIL); runCase("both_pulse");
    // R11 stray pulses during probing
    strayOn = 1'b1;
    setCls(0, 0, 0, 0, 3); setResp(R_FAIL, R_FAIL, R_FAIL); runCase("stray_sd_fail");
    setCls(0, 0, 0, 0, 0); runCase("stray_nostrap");
    // random mix
    for (int n = 0; n < 40; n++) begin
      cls[4] = ($urandom_range(3, 0) == 0) ? 2'($urandom_range(3, 2)) : 2'($urandom_range(1, 0));
      for (int k = 0; k < 4; k++) cls[k] = 2'($urandom_range(3, 0));
      for (int s = 0; s < 5; s++) resp[s] = $urandom_range(3, 0);
      respLat   = $urandom_range(5, 0);
      settleLen = 8'($urandom_range(12, 0));
      strayOn   = 1'($urandom_range(1, 0));
      runCase("random");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

endmodule